// File: doc/BRIEF.md
# Condition-Result Fail-First Vector Truncation Unit

This unit walks a vector of condition-register operations one element per cycle, from index 0 up to the programmed length minus one. Each element's result comes in on an operation port. The result is either a whole 4-bit condition field, when the operation names a field, or a single condition bit, when the operation names one bit. The unit selects the bit to test, compares it with an invert control, and stops the vector at the first element that fails. For every element it reports whether the result may be written, and at the end it reports the shortened vector length.

A vector starts with a one-cycle `start` pulse while the unit is idle. On that pulse it captures the length, the operand form, the field-bit selector, the invert control and the include-failing-element control. Results then arrive with a `res_valid` strobe. The write enable is combinational in the cycle of the result. `done` pulses one cycle after the element that ends the vector, and at that point `new_vl` holds the resulting length until the next vector ends.

Top module: `crff_trunc`

## Requirements
- R1: After reset `busy`, `done` and `wr_en` are 0, `new_vl` is 0 and `elem_idx` is 0.
- R2: In field form (`bit_form`=0) the tested bit is `res_field[crbit_sel]`, where index 0=LT, 1=GT, 2=EQ and 3=SO.
- R3: In single-bit form (`bit_form`=1) the tested bit is `res_bit`, and `res_field` and `crbit_sel` have no effect.
- R4: An element passes when its tested bit differs from `inv`. A passing element raises `wr_en` in its own cycle, and `elem_idx` then advances by one.
- R5: When the first failing element (tested bit equal to `inv`) arrives with `vli`=1, its `wr_en` is 1 and `new_vl` becomes its index plus one.
- R6: When the first failing element arrives with `vli`=0, its `wr_en` is 0 and `new_vl` becomes its index.
- R7: The cycle after the element that ends the vector, `done` is 1 for one cycle and `busy` is 0. No further `wr_en` occurs until the next `start`.
- R8: When no element fails, `new_vl` equals the captured length.
- R9: A `start` with length 0 gives `done`=1 and `new_vl`=0 in the next cycle, with no write.
- R10: While busy, a cycle with `res_valid`=0 produces no write and leaves `elem_idx` unchanged.
- R11: A `start` while busy is ignored, and `res_valid` while idle produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a vector (accepted only when idle) |
| vl_in | input | VLW | Vector length to process |
| bit_form | input | 1 | 1: single-bit result form, 0: 4-bit field form |
| crbit_sel | input | 2 | Bit of the field tested in field form (0=LT,1=GT,2=EQ,3=SO) |
| inv | input | 1 | Value of the tested bit that counts as failure |
| vli | input | 1 | 1: failing element is kept and counted |
| res_valid | input | 1 | Element result present this cycle |
| res_field | input | 4 | 4-bit field result |
| res_bit | input | 1 | Single-bit result |
| busy | output | 1 | A vector is in progress |
| elem_idx | output | VLW | Index of the element expected now |
| wr_en | output | 1 | Current element result may be written |
| done | output | 1 | One-cycle pulse: vector finished |
| new_vl | output | VLW | Resulting vector length, valid from `done` |

## Verification
The assertions assume that the operation port presents results only while `busy` is high, at most one per cycle, and that `start` is a single-cycle pulse. The bench drives every input at the falling edge and samples shortly afterwards, so each property sees stable values. Its stimulus does send results while idle and a second `start` mid-vector, and it does so on purpose to show that these are ignored. Each random vector draws its results from a shift-register sequence, with optional bias towards passing and optional stall cycles. This lets vectors of up to 20 elements both fail at varied positions and run to completion.

// File: rtl/crff_trunc.sv
module crff_trunc #(
  parameter int VLW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl_in,
  input  logic           bit_form,
  input  logic [1:0]     crbit_sel,
  input  logic           inv,
  input  logic           vli,
  input  logic           res_valid,
  input  logic [3:0]     res_field,
  input  logic           res_bit,
  output logic           busy,
  output logic [VLW-1:0] elem_idx,
  output logic           wr_en,
  output logic           done,
  output logic [VLW-1:0] new_vl
);
  logic [VLW-1:0] vl_q, idx_q, nvl_q;
  logic [1:0]     sel_q;
  logic           busy_q, done_q, form_q, inv_q, vli_q;

  wire tested = form_q ? res_bit : res_field[sel_q];
  wire fail   = (tested == inv_q);
  wire step   = busy_q & res_valid;
  wire last   = (idx_q == vl_q - 1'b1);

  assign wr_en    = step & (~fail | vli_q);
  assign busy     = busy_q;
  assign elem_idx = idx_q;
  assign done     = done_q;
  assign new_vl   = nvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      vl_q   <= '0;
      idx_q  <= '0;
      nvl_q  <= '0;
      sel_q  <= '0;
      form_q <= 1'b0;
      inv_q  <= 1'b0;
      vli_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        vl_q   <= vl_in;
        form_q <= bit_form;
        sel_q  <= crbit_sel;
        inv_q  <= inv;
        vli_q  <= vli;
        idx_q  <= '0;
        if (vl_in == '0) begin
          done_q <= 1'b1;
          nvl_q  <= '0;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (step) begin
        if (fail) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          nvl_q  <= vli_q ? idx_q + 1'b1 : idx_q;
        end else if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          nvl_q  <= vl_q;
        end else begin
          idx_q  <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

module crff_trunc_chk #(
  parameter int VLW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [VLW-1:0] vl_in,
  input logic           res_valid,
  input logic           busy,
  input logic [VLW-1:0] elem_idx,
  input logic           wr_en,
  input logic           done,
  input logic [VLW-1:0] new_vl
);
  a_r11_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !res_valid) |=> (busy && elem_idx == $past(elem_idx)));
  a_r6_drop_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && res_valid && !wr_en) |=> (done && new_vl == $past(elem_idx)));
  a_r5_write_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && res_valid && wr_en) |=>
      ((done && new_vl == $past(elem_idx) + 1'b1) ||
       (busy && elem_idx == $past(elem_idx) + 1'b1)));
  a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && vl_in == '0) |=> (done && !busy && new_vl == '0));
endmodule

bind crff_trunc crff_trunc_chk #(.VLW(VLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
  .res_valid(res_valid), .busy(busy), .elem_idx(elem_idx),
  .wr_en(wr_en), .done(done), .new_vl(new_vl)
);

// File: tb/sim_crff_trunc.sv
module sim_crff_trunc;
  localparam int VLW = 7;
  logic clk = 0, rst_n = 0, start = 0, bit_form = 0, inv = 0, vli = 0;
  logic res_valid = 0, res_bit = 0;
  logic [1:0] crbit_sel = 0;
  logic [3:0] res_field = 0;
  logic [VLW-1:0] vl_in = 0;
  logic busy, wr_en, done;
  logic [VLW-1:0] elem_idx, new_vl;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  crff_trunc #(.VLW(VLW)) u0 (.*);

  // {vl, form, sel, inv, vli, bias, stall, seed}
  localparam logic [29:0] TBL [0:9] = '{
    {7'd5,  1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 16'hACE1},
    {7'd8,  1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1234},
    {7'd3,  1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'hBEEF},
    {7'd12, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0F0F},
    {7'd1,  1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 16'h7777},
    {7'd16, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h5A5A},
    {7'd0,  1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0001},
    {7'd20, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 16'hC3C3},
    {7'd7,  1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 16'h2468},
    {7'd10, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 16'h9999}
  };

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int vl, input bit form, input logic [1:0] sel,
                     input bit iv, input bit vi, input bit bias, input bit stall,
                     input logic [15:0] seed);
    logic [15:0] s;
    int i, expn;
    bit ended, tested, fl, expw;
    s = seed | 16'h1;
    i = 0; ended = 0; expn = vl;
    @(negedge clk);
    start = 1; vl_in = VLW'(vl); bit_form = form; crbit_sel = sel; inv = iv; vli = vi;
    @(negedge clk);
    start = 0; bit_form = ~form; crbit_sel = ~sel; inv = ~iv; vli = ~vi;
    while (i < vl && !ended) begin
      s = nxt(s);
      res_field = s[3:0]; res_bit = s[4];
      if (stall && s[9:8] == 2'b00) begin
        res_valid = 0;
        #1 chk(wr_en == 0 && elem_idx == VLW'(i), "R10", wr_en, 0);
      end else begin
        if (bias && s[7:5] != 3'b000) begin
          if (form) res_bit = ~iv; else res_field[sel] = ~iv;
        end
        tested = form ? res_bit : res_field[sel];
        fl = (tested == iv);
        expw = !fl || vi;
        res_valid = 1;
        #1 chk(wr_en == expw && elem_idx == VLW'(i),
               fl ? (vi ? "R5" : "R6") : (form ? "R3/R4" : "R2/R4"), wr_en, expw);
        if (fl) begin
          ended = 1;
          expn = vi ? i + 1 : i;
        end else i++;
      end
      @(negedge clk);
    end
    res_valid = 1; res_field = s[7:4]; res_bit = s[0];
    #1 chk(done && !busy && !wr_en && new_vl == VLW'(expn),
           ended ? "R7" : (vl == 0 ? "R9" : "R8"), new_vl, expn);
    @(negedge clk);
    res_valid = 0;
    #1 chk(!done && !wr_en, "R7", done, 0);
  endtask

  task automatic one(input bit form, input logic [1:0] sel, input bit iv, input bit vi,
                     input logic [3:0] fld, input bit b, input bit expw, input int expn,
                     input string req);
    @(negedge clk);
    start = 1; vl_in = 1; bit_form = form; crbit_sel = sel; inv = iv; vli = vi;
    @(negedge clk);
    start = 0; res_valid = 1; res_field = fld; res_bit = b;
    #1 chk(wr_en == expw, req, wr_en, expw);
    @(negedge clk);
    res_valid = 0;
    #1 chk(done && new_vl == VLW'(expn), req, new_vl, expn);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1 chk(!busy && !done && !wr_en && new_vl == 0 && elem_idx == 0, "R1", busy, 0);
    rst_n = 1;
    // R11: result while idle is not written
    @(negedge clk);
    res_valid = 1; res_field = 4'hF;
    #1 chk(!wr_en && !busy, "R11", wr_en, 0);
    @(negedge clk);
    res_valid = 0;
    for (int k = 0; k < 10; k++)
      run(int'(TBL[k][29:23]), TBL[k][22], TBL[k][21:20], TBL[k][19], TBL[k][18],
          TBL[k][17], TBL[k][16], TBL[k][15:0]);
    for (int k = 0; k < 40; k++)
      run($urandom_range(0, 20), 1'($urandom), 2'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
    // R2: each field bit selects its own position (0=LT,1=GT,2=EQ,3=SO)
    one(0, 2'd2, 1, 1, 4'b0100, 0, 1, 1, "R2");
    one(0, 2'd1, 1, 0, 4'b0100, 0, 1, 1, "R2");
    one(0, 2'd3, 0, 0, 4'b0111, 1, 0, 0, "R2");
    one(0, 2'd0, 1, 0, 4'b1110, 1, 1, 1, "R2");
    // R3: field and selector ignored in single-bit form
    one(1, 2'd0, 0, 0, 4'b0000, 1, 1, 1, "R3");
    one(1, 2'd2, 1, 0, 4'b0000, 1, 0, 0, "R3");
    // R9: zero length
    run(0, 0, 2'd0, 0, 0, 0, 0, 16'h1);
    // R11: second start while busy is ignored
    @(negedge clk);
    start = 1; vl_in = 3; bit_form = 0; crbit_sel = 0; inv = 1; vli = 0;
    @(negedge clk);
    start = 1; vl_in = 0; res_valid = 0;
    @(negedge clk);
    start = 0;
    #1 chk(busy && !done && elem_idx == 0, "R11", busy, 1);
    for (int k = 0; k < 3; k++) begin
      res_valid = 1; res_field = 4'b0000;
      #1 chk(wr_en == 1, "R4", wr_en, 1);
      @(negedge clk);
    end
    res_valid = 0;
    #1 chk(done && new_vl == 3, "R8", new_vl, 3);
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule